// File: doc/BRIEF.md
# Byte-Wide External Memory Bus Sequencer

This block sits between a CPU data port and an external memory bus that is 8 bits wide with a 16-bit address. A CPU access can be one byte, a 16-bit half-word or a 32-bit word. The block splits each access into a run of byte cycles. For each byte cycle it drives the address, the data and a read or write strobe. One chip select, picked from seven by the top address bits, stays low for the whole access.

Reads fetch the most significant byte first, at ascending addresses. Writes send the least significant byte first, at descending addresses. Memory is therefore big-endian in both directions, even though the two directions walk it in opposite orders. A slow device holds a ready input low to stretch the strobe one clock at a time. The CPU sees a single-clock done pulse after the last byte. For reads, the assembled value appears on the read-data output in that same clock.

Top module: `xbus_seq`

## Requirements
- R1: The size input selects the number of byte cycles: 0 gives one (byte), 1 gives two (half-word), and 2 or 3 give four (word).
- R2: A read of n bytes from base address B visits addresses B, B+1, … B+n-1 in that order. The first byte fetched becomes the most significant byte of the result. The result is zero-extended into the 32-bit read data.
- R3: A write of n bytes to base B visits addresses B+n-1 down to B. Byte i of the cycle order carries write-data bits [8i+7:8i], so the least significant byte goes first.
- R4: The base address is the request address with its low bits cleared: none for a byte, bit 0 for a half-word, bits 1:0 for a word.
- R5: When address bits [15:13] hold a value k below 7, cs_n[k] goes low from the first byte cycle's setup clock until the access completes. A value of 7 asserts no chip select. At most one chip select is ever low, and all are high once done is seen.
- R6: With ready held high, each byte cycle takes three clocks, in this order:
  - a setup clock, with address and chip select valid and both strobes high;
  - one strobe-low clock;
  - a hold clock, with the strobe high and address, chip select and write data unchanged.
  
  done is high for exactly one clock, 3n clocks after the clock edge that accepted the request.
- R7: Each clock edge that finds ready low while a strobe is low keeps that strobe low for one more clock and delays done by one clock. Read data is captured on the edge where ready is high.
- R8: Read data changes only when a read completes. It is held while an access runs, and a write leaves it unchanged.
- R9: A request raised while an access is in progress is ignored and starts no byte cycles.
- R10: After reset, all chip selects and both strobes are high, the data-drive enable is low, done is low and read data is zero.
- R11: The data-drive enable is high throughout every write byte cycle and low during reads. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request; accepted only when idle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| addr | input | 16 | Request address |
| wdata | input | 32 | Write value; low byte used for byte writes |
| done | output | 1 | One-clock pulse when the access ends |
| rdata | output | 32 | Assembled read value |
| ext_addr | output | 16 | External byte address |
| ext_dout | output | 8 | External write data |
| ext_oe | output | 1 | Drive enable for external write data |
| ext_din | input | 8 | External read data |
| ready | input | 1 | Low stretches the current strobe |
| cs_n | output | 7 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Directed accesses cover each size in both directions:
- aligned and misaligned request addresses, which separate the base masking from the byte walk;
- the unmapped top region, which shows whether the chip-select decode stays silent there;
- size code 3, which must behave as a word;
- a second request injected mid-access, which shows whether a busy sequencer starts extra cycles.

The external memory returns a byte computed from the address. A wrong address order therefore shows up both in the logged addresses and in the assembled read value.

Random accesses run under three ready patterns: always ready, randomly stalled, and ready one clock in four. The measured latency must track the observed stall count exactly, which separates the fixed cycle length from the wait extension.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/xbus_csdec.sv
module xbus_csdec #(
  parameter int NUM_CS = 7,
  localparam int SEL_W = $clog2(NUM_CS + 1)
) (
  input  logic [SEL_W-1:0]  region,
  output logic [NUM_CS-1:0] sel_n
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign sel_n[g] = (region != SEL_W'(g));
  end

endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes #(
  parameter int CPU_W = 32,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cap,
  input  logic             adv,
  input  logic             fin_rd,
  input  logic [CPU_W-1:0] wdata,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic [CPU_W-1:0] rdata
);

  localparam int SH_W = CPU_W - BUS_W;

  logic [SH_W-1:0]  wq;
  logic [CPU_W-1:0] rq;

  // write lanes leave low byte first; read lanes fill from the bottom
  always_ff @(posedge clk) begin
    if (rst) begin
      wq    <= '0;
      rq    <= '0;
      dout  <= '0;
      rdata <= '0;
    end else begin
      if (start) begin
        dout <= wdata[BUS_W-1:0];
        wq   <= wdata[CPU_W-1:BUS_W];
        rq   <= '0;
      end else if (adv) begin
        dout <= wq[BUS_W-1:0];
        wq   <= wq >> BUS_W;
      end
      if (cap) rq <= {rq[CPU_W-BUS_W-1:0], din};
      if (fin_rd) rdata <= rq;
    end
  end

  // R8: result register moves only on a read completion
  a_r8_rdata_only_at_end: assert property (@(posedge clk) disable iff (rst)
    (!fin_rd && !rst) |=> $stable(rdata));

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 32,
  parameter int BUS_W  = 8,
  localparam int LANES = CPU_W / BUS_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ready,
  output logic [ADDR_W-1:0] req_base,
  output logic              start,
  output logic              cap,
  output logic              adv,
  output logic              fin,
  output logic              fin_rd,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              rd_n,
  output logic              wr_n,
  output logic              oe,
  output logic              done
);

  phase_e           ph;
  logic [IDX_W-1:0] idx, last, req_last;
  logic             wr_q;

  always_comb begin
    case (size)
      SZ_BYTE: req_last = '0;
      SZ_HALF: req_last = IDX_W'(1);
      default: req_last = IDX_W'(LANES - 1);
    endcase
    req_base = addr & ~ADDR_W'(req_last);
  end

  assign start  = (ph == PH_IDLE) && req;
  assign cap    = (ph == PH_STROBE) && ready && !wr_q;
  assign adv    = (ph == PH_HOLD) && (idx != last);
  assign fin    = (ph == PH_HOLD) && (idx == last);
  assign fin_rd = fin && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      last     <= '0;
      wr_q     <= 1'b0;
      ext_addr <= '0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      oe       <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (req) begin
          ph       <= PH_SETUP;
          idx      <= '0;
          last     <= req_last;
          wr_q     <= we;
          oe       <= we;
          ext_addr <= we ? req_base + ADDR_W'(req_last) : req_base;
        end
        PH_SETUP: begin
          ph   <= PH_STROBE;
          rd_n <= wr_q;
          wr_n <= !wr_q;
        end
        PH_STROBE: if (ready) begin
          ph   <= PH_HOLD;
          rd_n <= 1'b1;
          wr_n <= 1'b1;
        end
        PH_HOLD: if (idx == last) begin
          ph   <= PH_IDLE;
          oe   <= 1'b0;
          done <= 1'b1;
        end else begin
          ph       <= PH_SETUP;
          idx      <= idx + IDX_W'(1);
          ext_addr <= wr_q ? ext_addr - ADDR_W'(1) : ext_addr + ADDR_W'(1);
        end
      endcase
    end
  end

  // R11: never both strobes at once
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R11: data driven during write strobes, released during read strobes
  a_r11_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> oe);
  a_r11_float_on_read: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !oe);
  // R7: a stalled strobe stays low
  a_r7_wait_read: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);
  a_r7_wait_write: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ready) |=> !wr_n);
  // R6: address held through strobe and the following clock
  a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |=> $stable(ext_addr));
  // R6: done is a single-clock pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 32,
  parameter int BUS_W  = 8,
  parameter int NUM_CS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  wdata,
  output logic              done,
  output logic [CPU_W-1:0]  rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BUS_W-1:0]  ext_dout,
  output logic              ext_oe,
  input  logic [BUS_W-1:0]  ext_din,
  input  logic              ready,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rd_n,
  output logic              wr_n
);

  localparam int SEL_W = $clog2(NUM_CS + 1);

  logic [ADDR_W-1:0] req_base;
  logic [NUM_CS-1:0] dec_n;
  logic start, cap, adv, fin, fin_rd;

  xbus_fsm #(.ADDR_W(ADDR_W), .CPU_W(CPU_W), .BUS_W(BUS_W)) u_fsm (
    .clk(clk), .rst(rst), .req(req), .we(we), .size(size), .addr(addr),
    .ready(ready), .req_base(req_base), .start(start), .cap(cap),
    .adv(adv), .fin(fin), .fin_rd(fin_rd), .ext_addr(ext_addr),
    .rd_n(rd_n), .wr_n(wr_n), .oe(ext_oe), .done(done)
  );

  xbus_lanes #(.CPU_W(CPU_W), .BUS_W(BUS_W)) u_lanes (
    .clk(clk), .rst(rst), .start(start), .cap(cap), .adv(adv),
    .fin_rd(fin_rd), .wdata(wdata), .din(ext_din), .dout(ext_dout),
    .rdata(rdata)
  );

  xbus_csdec #(.NUM_CS(NUM_CS)) u_dec (
    .region(req_base[ADDR_W-1 -: SEL_W]),
    .sel_n (dec_n)
  );

  // chip select held across every byte cycle of one access
  always_ff @(posedge clk) begin
    if (rst)        cs_n <= '1;
    else if (start) cs_n <= dec_n;
    else if (fin)   cs_n <= '1;
  end

  // R5: at most one device selected
  a_r5_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R5: selects released by the time done is seen
  a_r5_cs_released: assert property (@(posedge clk) disable iff (rst)
    done |-> (&cs_n));

endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        done, ext_oe, ready, rd_n, wr_n;
  logic [31:0] rdata;
  logic [15:0] ext_addr;
  logic [7:0]  ext_dout, ext_din;
  logic [6:0]  cs_n;

  int checks = 0, errors = 0, wait_mode = 0, pc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .done(done), .rdata(rdata), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_oe(ext_oe), .ext_din(ext_din), .ready(ready),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign ext_din = mem_byte(ext_addr);

  initial begin
    ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (wait_mode)
        0: ready = 1'b1;
        1: ready = ($urandom % 3) != 0;
        default: begin pc++; ready = (pc % 4 == 3); end
      endcase
    end
  end

  // bus monitor, sampled on the falling edge
  logic [15:0] log_addr [8];
  logic [7:0]  log_dat  [8];
  logic [6:0]  log_cs   [8];
  logic        log_oe   [8];
  int nlog = 0, nwait = 0, hold_bad = 0;
  logic prev_strobe = 1'b0;

  always @(negedge clk) begin
    if ((!rd_n || !wr_n) && !prev_strobe && nlog < 8) begin
      log_addr[nlog] = ext_addr;
      log_dat[nlog]  = ext_dout;
      log_cs[nlog]   = cs_n;
      log_oe[nlog]   = ext_oe;
      nlog++;
    end
    if ((!rd_n || !wr_n) && !ready) nwait++;
    if (rd_n && wr_n && prev_strobe && nlog > 0) begin
      if (ext_addr != log_addr[nlog-1] || cs_n != log_cs[nlog-1] ||
          ext_oe != log_oe[nlog-1] || (ext_oe && ext_dout != log_dat[nlog-1]))
        hold_bad++;
    end
    prev_strobe = !rd_n || !wr_n;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_access(input logic w, input logic [1:0] sz,
                           input logic [15:0] a, input logic [31:0] d,
                           input int wm, input bit inject);
    int n, lat;
    logic [15:0] base, ea;
    logic [31:0] exp_rd, prev_rd;
    logic [6:0]  exp_cs;
    bit stable_ok;
    string ttag, atag;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    base = a & ~16'(n - 1);
    exp_cs = (a[15:13] == 3'd7) ? 7'h7F : ~(7'd1 << a[15:13]);
    exp_rd = '0;
    for (int i = 0; i < n; i++) exp_rd = (exp_rd << 8) | 32'(mem_byte(base + 16'(i)));
    @(negedge clk);
    wait_mode = wm; nlog = 0; nwait = 0; hold_bad = 0; prev_rd = rdata;
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1; stable_ok = 1'b1;
    while (!done && lat < 200) begin
      if (rdata !== prev_rd) stable_ok = 1'b0;
      if (inject && lat == 2) begin
        req = 1'b1; we = ~w; size = 2'd2; addr = ~a; wdata = ~d;
      end else req = 1'b0;
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    ttag = (wm == 0) ? "R6" : "R7";
    chk(done, "R6", "done pulse seen", 32'(done), 32'd1);
    chk(lat == 3*n + nwait + 1, ttag, "access latency", 32'(lat), 32'(3*n + nwait + 1));
    chk(nlog == n, "R1", "byte cycle count", 32'(nlog), 32'(n));
    atag = (a != base) ? "R4" : (w ? "R3" : "R2");
    for (int i = 0; i < n && i < nlog; i++) begin
      ea = w ? base + 16'(n - 1 - i) : base + 16'(i);
      chk(log_addr[i] == ea, atag, "byte address", 32'(log_addr[i]), 32'(ea));
      chk(log_cs[i] == exp_cs, "R5", "chip select", 32'(log_cs[i]), 32'(exp_cs));
      chk(log_oe[i] == w, "R11", "drive enable", 32'(log_oe[i]), 32'(w));
      if (w) chk(log_dat[i] == d[8*i +: 8], "R3", "write byte", 32'(log_dat[i]), 32'(d[8*i +: 8]));
    end
    chk(hold_bad == 0, "R6", "hold clock keeps addr/cs/data", 32'(hold_bad), 32'd0);
    chk(stable_ok, "R8", "rdata stable while busy", 32'(stable_ok), 32'd1);
    if (!w) chk(rdata == exp_rd, "R2", "assembled read", rdata, exp_rd);
    else    chk(rdata == prev_rd, "R8", "write leaves rdata", rdata, prev_rd);
    @(negedge clk);
    chk(!done, "R6", "done lasts one clock", 32'(done), 32'd0);
    chk(cs_n == 7'h7F && !ext_oe && rd_n && wr_n, "R5", "bus released",
        {cs_n, ext_oe, rd_n, wr_n}, {7'h7F, 3'b011});
    if (inject) begin
      repeat (6) @(negedge clk);
      chk(nlog == n, "R9", "busy request ignored", 32'(nlog), 32'(n));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 7'h7F && rd_n && wr_n && !ext_oe && !done && rdata == 0, "R10",
        "reset state", {rdata[23:0], cs_n, ext_oe}, {24'd0, 7'h7F, 1'b0});

    do_access(1'b0, 2'd2, 16'h4010, 32'h0, 0, 1'b0);          // R2 word read
    do_access(1'b1, 2'd2, 16'hC020, 32'h11223344, 0, 1'b0);   // R3 word write
    do_access(1'b0, 2'd1, 16'h2035, 32'h0, 0, 1'b0);          // R4 half read misaligned
    do_access(1'b1, 2'd1, 16'h6001, 32'hAABBCCDD, 0, 1'b0);   // R4 half write misaligned
    do_access(1'b0, 2'd0, 16'h0003, 32'h0, 0, 1'b0);          // R1 byte read
    do_access(1'b1, 2'd0, 16'hE0FF, 32'h000000E7, 0, 1'b0);   // R5 unmapped region
    do_access(1'b0, 2'd3, 16'hA007, 32'h0, 0, 1'b0);          // R1 size code 3
    do_access(1'b1, 2'd2, 16'h8102, 32'h0F1E2D3C, 2, 1'b0);   // R7 long waits
    do_access(1'b0, 2'd2, 16'h3FFC, 32'h0, 2, 1'b1);          // R9 inject on read
    do_access(1'b1, 2'd1, 16'h5550, 32'h12345678, 1, 1'b1);   // R9 inject on write

    for (int k = 0; k < 60; k++) begin
      do_access(1'($urandom % 2), 2'($urandom % 4), 16'($urandom),
                $urandom, int'($urandom % 3), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule